// File: doc/BRIEF.md
# Serial Lane Power Sequencer

This block switches the power-down controls of up to four serial transmit lanes, one lane at a time, in a fixed order. Software writes a single command word. The word holds a start bit, the requested lane state, the order in which to visit the lanes, a lane-count code and a step delay. An accepted command walks the enabled lanes one by one. Before each lane switches, the block waits a programmable number of prescaled ticks. The analog pads are represented only by one power-down output bit per lane, where 1 means the lane is powered down.

The same register reads back the stored command fields and the progress of the command. The start bit stays at 1 while a sequence runs and returns to 0 when the last lane has switched, and at that point a done flag rises. Software therefore polls one word until it shows completion. By convention a power-up command walks the lanes from the highest enabled lane down to lane 0, and a power-down command walks from lane 0 upward. The order bit in the command selects the walk, so software sets it to match the requested state. An electrical-style link would use a step delay of 15, and a packet-style link a delay of 1.

The controller has two states. S_IDLE waits for a command. It moves to S_WAIT when a write arrives that has the start bit set and a legal lane count. S_WAIT counts ticks and switches one lane each time the count reaches the programmed delay. It returns to S_IDLE on the step that switches the last enabled lane.

Top module: `lane_pwr_seq`

## Requirements
- R1: After reset every pd_lane bit is 1 and rd_data reads 0.
- R2: The command word uses these fields: bit 0 is start, bit 1 is the target state (1 = power up, which drives pd to 0; 0 = power down, which drives pd to 1), bit 2 is the order (0 = ascending from lane 0, 1 = descending from the highest enabled lane), bits 5:3 are the lane count and bits 9:6 are the step delay. When a command completes, every enabled lane holds the target state.
- R3: Each lane switches exactly (delay+1)*TICK_DIV clock cycles after the accepting edge or after the previous lane's switch.
- R4: Lanes switch one per step, in ascending order when the order bit is 0 and in descending order when it is 1.
- R5: While a sequence runs, every write is ignored. The lane sequence, the timing and the stored fields all continue unchanged.
- R6: A lane count of 1 enables lane 0, a count of 2 enables lanes 0 and 1, and a count of 4 enables lanes 0 to 3. On the accepting edge, lanes above the enabled set are driven to 1 and held there.
- R7: rd_data bit 0 reads 1 from the accepting edge until the edge that switches the last lane. On that edge it returns to 0 and bit 12 (done) becomes 1. The next accepted command clears done.
- R8: A command whose start bit is set but whose lane count is anything other than 1, 2 or 4 sets a sticky error flag at bit 13. It starts no sequence and changes no lane. The error flag clears when a legal command is accepted.
- R9: A write with bit 0 clear has no effect on rd_data or pd_lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 16 | Command word |
| rd_data | output | 16 | Stored command fields and status |
| pd_lane | output | 4 | Per-lane power-down control, 1 = powered down |

## Verification
The bench checks the lane outputs and the status word on every cycle of each sequence. A wrong prescaler phase or a skipped tick therefore appears as a lane switching one cycle early or late. Commands with a lane count of 1 and of 2 check that the upper lanes are forced off on the accepting edge and not later. A design that decoded the count loosely would leave those lanes on. Illegal count codes 0, 3 and 7 must leave the lanes untouched. A write injected in the middle of a sequence must not restart the walk or alter the stored fields. A design that accepted it would show a reset delay count or the wrong lane order.

// File: rtl/lps_pkg.sv
package lps_pkg;
    localparam int LANES   = 4;
    localparam int IDX_W   = $clog2(LANES);
    localparam int REG_W   = 16;
    localparam int CNT_W   = 3;
    localparam int B_GO    = 0;
    localparam int B_UP    = 1;
    localparam int B_DIR   = 2;
    localparam int CNT_LSB = 3;
    localparam int DLY_LSB = 6;
    localparam int B_DONE  = 12;
    localparam int B_ERR   = 13;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } lps_state_t;
endpackage

// File: rtl/lps_tick_gen.sv
module lps_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST) && !clr;

    generate
        if (TICK_DIV > 1) begin : g_chk
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate
endmodule

// File: rtl/lps_lane_decode.sv
module lps_lane_decode
    import lps_pkg::*;
(
    input  logic [CNT_W-1:0] code,
    output logic             valid,
    output logic [LANES-1:0] mask,
    output logic [IDX_W-1:0] last
);
    always_comb begin
        valid = (code == CNT_W'(1)) || (code == CNT_W'(2)) || (code == CNT_W'(4));
        last  = valid ? IDX_W'(code - CNT_W'(1)) : '0;
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_mask
            assign mask[g] = valid && (CNT_W'(g) < code);
        end
    endgenerate
endmodule

// File: rtl/lps_lane_bank.sv
module lps_lane_bank
    import lps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_en,
    input  logic [LANES-1:0] force_mask,
    input  logic             step_en,
    input  logic [IDX_W-1:0] step_idx,
    input  logic             step_val,
    output logic [LANES-1:0] pd
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic lane_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         lane_q <= 1'b1;
                else if (force_en && force_mask[g]) lane_q <= 1'b1;
                else if (step_en && step_idx == IDX_W'(g)) lane_q <= step_val;
            end
            assign pd[g] = lane_q;
        end
    endgenerate

    AST_ONE_LANE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !force_en |=> ($countones(pd ^ $past(pd)) <= 1)); // R4
endmodule

// File: rtl/lane_pwr_seq.sv
module lane_pwr_seq
    import lps_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int DLY_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [LANES-1:0] pd_lane
);
    lps_state_t state_q, state_d;

    logic             up_q, dir_q, done_q, err_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_q, tcnt_q;
    logic [IDX_W-1:0] idx_q, last_q;
    logic [LANES-1:0] wr_mask, cur_mask;
    logic             wr_valid, cur_valid, tick;
    logic             accept, start, reject, step, last_step;
    logic [CNT_W-1:0] wr_cnt;

    assign wr_cnt = wr_data[CNT_LSB +: CNT_W];

    lps_lane_decode u_wr_dec (
        .code (wr_cnt),
        .valid(wr_valid),
        .mask (wr_mask),
        .last ()
    );

    lps_lane_decode u_cur_dec (
        .code (cnt_q),
        .valid(cur_valid),
        .mask (cur_mask),
        .last (last_q)
    );

    lps_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .tick (tick)
    );

    lps_lane_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_en  (start),
        .force_mask(~wr_mask),
        .step_en   (step),
        .step_idx  (idx_q),
        .step_val  (~up_q),
        .pd        (pd_lane)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        accept    = wr_en && wr_data[B_GO] && (state_q == S_IDLE);
        start     = 1'b0;
        reject    = 1'b0;
        step      = 1'b0;
        last_step = dir_q ? (idx_q == '0) : (idx_q == last_q);
        unique case (state_q)
            S_IDLE: begin
                if (accept && wr_valid) begin
                    start   = 1'b1;
                    state_d = S_WAIT;
                end else if (accept) begin
                    reject  = 1'b1;
                end
            end
            S_WAIT: begin
                if (tick && tcnt_q == dly_q) begin
                    step = 1'b1;
                    if (last_step) state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Command storage and step bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q   <= 1'b0;
            dir_q  <= 1'b0;
            cnt_q  <= '0;
            dly_q  <= '0;
            tcnt_q <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start) begin
            up_q   <= wr_data[B_UP];
            dir_q  <= wr_data[B_DIR];
            cnt_q  <= wr_cnt;
            dly_q  <= wr_data[DLY_LSB +: DLY_W];
            tcnt_q <= '0;
            idx_q  <= wr_data[B_DIR] ? IDX_W'(wr_cnt - CNT_W'(1)) : '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (reject) begin
            err_q  <= 1'b1;
        end else if (step) begin
            tcnt_q <= '0;
            if (last_step) done_q <= 1'b1;
            else           idx_q  <= dir_q ? idx_q - 1'b1 : idx_q + 1'b1;
        end else if (state_q == S_WAIT && tick) begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[B_GO]               = (state_q == S_WAIT);
        rd_data[B_UP]               = up_q;
        rd_data[B_DIR]              = dir_q;
        rd_data[CNT_LSB +: CNT_W]   = cnt_q;
        rd_data[DLY_LSB +: DLY_W]   = dly_q;
        rd_data[B_DONE]             = done_q;
        rd_data[B_ERR]              = err_q;
    end

    AST_REJECT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_valid) |=> ($stable(pd_lane) && state_q == S_IDLE && err_q)); // R8
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && wr_en) |=> ($stable(up_q) && $stable(dly_q) && $stable(cnt_q) && $stable(dir_q))); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && state_q == S_WAIT)); // R7
    AST_UNUSED_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && cur_valid) |-> ((pd_lane & ~cur_mask) == ~cur_mask)); // R6
endmodule

// File: tb/sim_lane_pwr_seq.sv
module sim_lane_pwr_seq;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n, wr_en;
    logic [15:0] wr_data, rd_data;
    logic [3:0]  pd_lane;

    int errs = 0, checks = 0;
    bit finished = 0;

    logic [3:0] exp_pd;
    logic       s_up, s_dir, s_done, s_err;
    logic [2:0] s_cnt;
    logic [3:0] s_dly;

    always #4 clk = ~clk;

    lane_pwr_seq #(.TICK_DIV(DIV), .DLY_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pd_lane(pd_lane)
    );

    function automatic logic [15:0] mk_cmd(logic go, logic up, logic dir,
                                           logic [2:0] cnt, logic [3:0] dly);
        logic [15:0] w = '0;
        w[0] = go; w[1] = up; w[2] = dir; w[5:3] = cnt; w[9:6] = dly;
        return w;
    endfunction

    function automatic logic [15:0] mk_rd(logic go);
        logic [15:0] w = mk_cmd(go, s_up, s_dir, s_cnt, s_dly);
        w[12] = s_done; w[13] = s_err;
        return w;
    endfunction

    function automatic bit legal(logic [2:0] c);
        return (c == 3'd1) || (c == 3'd2) || (c == 3'd4);
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_cmd(logic up, logic dir, logic [2:0] cnt, logic [3:0] dly, bit poke);
        int n, per, lane;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = mk_cmd(1'b1, up, dir, cnt, dly);
        @(negedge clk);
        wr_en = 1'b0;
        if (!legal(cnt)) begin
            s_err = 1'b1;
            chk("R8 status after illegal count", rd_data, mk_rd(1'b0));
            chk("R8 lanes unchanged", {12'h0, pd_lane}, {12'h0, exp_pd});
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk("R8 no sequence started", {12'h0, pd_lane}, {12'h0, exp_pd});
            end
            return;
        end
        s_up = up; s_dir = dir; s_cnt = cnt; s_dly = dly; s_done = 1'b0; s_err = 1'b0;
        n = int'(cnt);
        per = (int'(dly) + 1) * DIV;
        for (int i = 0; i < 4; i++) if (i >= n) exp_pd[i] = 1'b1;
        for (int m = 0; m <= n * per; m++) begin
            if (m > 0) @(negedge clk);
            if (m > 0 && (m % per) == 0) begin
                lane = dir ? (n - (m / per)) : ((m / per) - 1);
                exp_pd[lane] = ~up;
                if (m == n * per) s_done = 1'b1;
            end
            chk("R3 R4 R6 lane timing and order", {12'h0, pd_lane}, {12'h0, exp_pd});
            chk("R7 status during sequence", rd_data, mk_rd(m < n * per));
            if (poke && m == 2) begin
                wr_en = 1'b1;
                wr_data = mk_cmd(1'b1, ~up, ~dir, 3'd4, 4'd0); // R5 write while busy
            end else begin
                wr_en = 1'b0;
            end
        end
        chk("R2 final lanes", {12'h0, pd_lane & 4'(( 1 << n) - 1)},
            {12'h0, (up ? 4'h0 : 4'hF) & 4'((1 << n) - 1)});
    endtask

    task automatic idle_write(logic [15:0] w);
        logic [15:0] before_rd;
        logic [3:0]  before_pd;
        @(negedge clk);
        before_rd = rd_data; before_pd = pd_lane;
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 no-start write keeps status", rd_data, before_rd);
        chk("R9 no-start write keeps lanes", {12'h0, pd_lane}, {12'h0, before_pd});
        @(negedge clk);
        chk("R9 still unchanged", {12'h0, pd_lane}, {12'h0, before_pd});
    endtask

    initial begin
        int unsigned seed_val;
        logic [2:0] c;
        seed_val = $urandom(32'd1207);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        exp_pd = 4'hF;
        s_up = 0; s_dir = 0; s_cnt = 0; s_dly = 0; s_done = 0; s_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset lanes", {12'h0, pd_lane}, 16'h000F);
        chk("R1 reset status", rd_data, 16'h0000);

        // Directed corner cases
        run_cmd(1'b1, 1'b1, 3'd4, 4'd0, 1'b0);   // R2 R4 power up descending, shortest delay
        run_cmd(1'b0, 1'b0, 3'd4, 4'd15, 1'b0);  // R3 power down ascending, longest delay
        run_cmd(1'b1, 1'b1, 3'd2, 4'd1, 1'b1);   // R5 R6 two lanes with busy write
        run_cmd(1'b1, 1'b1, 3'd4, 4'd2, 1'b0);
        run_cmd(1'b1, 1'b1, 3'd1, 4'd15, 1'b0);  // R6 one lane, upper lanes forced off
        run_cmd(1'b1, 1'b0, 3'd0, 4'd3, 1'b0);   // R8 count 0
        run_cmd(1'b1, 1'b0, 3'd3, 4'd3, 1'b0);   // R8 count 3
        run_cmd(1'b0, 1'b1, 3'd7, 4'd3, 1'b0);   // R8 count 7
        idle_write(mk_cmd(1'b0, 1'b1, 1'b1, 3'd4, 4'd5)); // R9
        run_cmd(1'b0, 1'b0, 3'd1, 4'd1, 1'b1);   // R8 error cleared by legal command

        // Constrained random
        for (int k = 0; k < 40; k++) begin
            case ($urandom % 5)
                0: c = 3'd1;
                1: c = 3'd2;
                2, 3: c = 3'd4;
                default: c = 3'($urandom % 8);
            endcase
            if ($urandom % 6 == 0) idle_write(mk_cmd(1'b0, 1'($urandom), 1'($urandom), c, 4'($urandom)));
            run_cmd(1'($urandom), 1'($urandom), c, 4'($urandom % 8), ($urandom % 3) == 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired, run hung");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule